// File: doc/BRIEF.md
# Mixed-Width Dual-Clock FIFO with Threshold Flags

This block is a dual-clock FIFO controller with its storage inside. The write and read ports run on separate clocks and may have different data widths, each a power of two. Both sides keep their positions as bit addresses into a storage of `2**ADDR_W` bits. Each side's pointer is a word counter scaled to bits, with one extra wrap bit. The fill level is the write bit address minus the read bit address, so it is counted in bits. The almost-full and almost-empty thresholds are also given in bits, which lets the two ports share one scale even when their word sizes differ.

FULL is raised on the write side as soon as a whole write word no longer fits. EMPTY is raised on the read side as soon as a whole read word is not present. Each pointer crosses to the other domain as Gray code through two flip-flops. Each side has a stop input that picks between two behaviours at its boundary. When the stop input is high, a request at the boundary is blocked. When it is low, the counter keeps counting and wraps, so data can be overwritten or read again.

Top module: `mwfifo`

## Requirements
- R1: While rst_ni is low and after its release, with no traffic, empty_o=1, full_o=0, aempty_o=1, and afull_o=0 for any nonzero almost-full threshold.
- R2: A write word's bit i is stored at bit address wptr+i. A read word's bit j comes from bit address rptr+j. With an 8-bit write and 4-bit reads, the low nibble is read first.
- R3: full_o is high whenever fewer than WR_W bits are free. A full FIFO with WR_W=8 and RD_W=4 stays full after one 4-bit read and leaves full only after the second.
- R4: empty_o is high whenever fewer than RD_W bits are stored.
- R5: afull_o, in the write domain, is high exactly when the bit level is greater than or equal to afull_thr_i.
- R6: aempty_o, in the read domain, is high exactly when the bit level is less than or equal to aempty_thr_i.
- R7: After a write into an empty FIFO, empty_o is still high after the first rising read-clock edge and falls after the second.
- R8: rdata_o is registered. It takes the new word at the read-clock edge that accepts a read and holds its value in every cycle with no accepted read.
- R9: With estop_i high, a read request while empty_o is high is ignored: the read pointer and rdata_o stay unchanged.
- R10: With fstop_i high, a write request while full_o is high is ignored: the memory and the write pointer stay unchanged.
- R11: Every accepted access advances its counter by one word, wrapping to zero after the last. With fstop_i low, a write while full overwrites the oldest word. With estop_i low, a read while empty re-reads the old contents.
- R12: Each pointer crosses clock domains as Gray code that changes at most one bit per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_i | input | 1 | Write request |
| wdata_i | input | WR_W | Write data |
| fstop_i | input | 1 | Block writes while full (1) or let the counter wrap (0) |
| afull_thr_i | input | ADDR_W | Almost-full threshold in bits |
| full_o | output | 1 | A whole write word does not fit |
| afull_o | output | 1 | Bit level >= almost-full threshold |
| rclk_i | input | 1 | Read clock |
| rd_en_i | input | 1 | Read request |
| rdata_o | output | RD_W | Registered read data |
| estop_i | input | 1 | Block reads while empty (1) or let the counter wrap (0) |
| aempty_thr_i | input | ADDR_W | Almost-empty threshold in bits |
| empty_o | output | 1 | A whole read word is not present |
| aempty_o | output | 1 | Bit level <= almost-empty threshold |

## Verification
On every cycle, the assertions check the following. Each crossing Gray pointer changes at most one bit. A blocked request at the boundary leaves its counter frozen. An accepted access moves its counter exactly one word. The read register holds when no read is accepted. Only the directed scenarios can show the rest, because those behaviours need the bench's own model of the fill level and of the data order. They cover the bit-level threshold crossings, the partial-word FULL case, the two-edge EMPTY delay, and the overwrite and re-read results of the wrapping modes.

// File: rtl/mwfifo_pkg.sv
`timescale 1ns/1ps
package mwfifo_pkg;
  function automatic logic [31:0] bin2gray(logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/mwfifo_sync.sv
`timescale 1ns/1ps
module mwfifo_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/mwfifo_ctrl.sv
`timescale 1ns/1ps
module mwfifo_ctrl
  import mwfifo_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int OWN_SH  = 3,
  parameter int PEER_SH = 2,
  parameter bit IS_WR   = 1'b1,
  localparam int PTR_W   = ADDR_W + 1,
  localparam int OWN_CW  = PTR_W - OWN_SH,
  localparam int PEER_CW = PTR_W - PEER_SH
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               stop_i,
  input  logic [ADDR_W-1:0]  thr_i,
  input  logic [PEER_CW-1:0] peer_gray_i,
  output logic [OWN_CW-1:0]  own_gray_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               acc_o,
  output logic               bound_o,
  output logic               thresh_o
);
  localparam int CAP   = 1 << ADDR_W;
  localparam int OWN_W = 1 << OWN_SH;

  logic [OWN_CW-1:0]  cnt_q, cnt_d, gray_q;
  logic [PEER_CW-1:0] peer_gray_s, peer_cnt;
  logic [PTR_W-1:0]   own_bits, peer_bits, level;

  mwfifo_sync #(.W(PEER_CW)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (peer_gray_i),
    .q_o   (peer_gray_s)
  );

  assign peer_cnt  = PEER_CW'(gray2bin(32'(peer_gray_s)));
  assign own_bits  = PTR_W'(cnt_q) << OWN_SH;
  assign peer_bits = PTR_W'(peer_cnt) << PEER_SH;

  generate
    if (IS_WR) begin : g_wr
      assign level    = own_bits - peer_bits;
      assign bound_o  = level > PTR_W'(CAP - OWN_W);
      assign thresh_o = level >= PTR_W'(thr_i);
    end else begin : g_rd
      assign level    = peer_bits - own_bits;
      assign bound_o  = level < PTR_W'(OWN_W);
      assign thresh_o = level <= PTR_W'(thr_i);
    end
  endgenerate

  assign acc_o = req_i & ~(bound_o & stop_i);
  assign cnt_d = cnt_q + OWN_CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      gray_q <= '0;
    end else if (acc_o) begin
      cnt_q  <= cnt_d;
      gray_q <= OWN_CW'(bin2gray(32'(cnt_d)));
    end
  end

  assign own_gray_o = gray_q;
  assign addr_o     = own_bits[ADDR_W-1:0];

  AST_GRAY_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gray_q ^ $past(gray_q)) <= 1); // R12

  AST_STEP_ONE_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o |=> cnt_q == $past(cnt_q) + OWN_CW'(1)); // R11

  generate
    if (IS_WR) begin : g_ast_wr
      AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && stop_i && bound_o) |=> $stable(cnt_q)); // R10
    end else begin : g_ast_rd
      AST_EMPTY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && stop_i && bound_o) |=> $stable(cnt_q)); // R9
    end
  endgenerate
endmodule

// File: rtl/mwfifo_mem.sv
`timescale 1ns/1ps
module mwfifo_mem #(
  parameter int ADDR_W = 12,
  parameter int WR_W   = 8,
  parameter int RD_W   = 4
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WR_W-1:0]   wdata_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [RD_W-1:0]   rdata_o
);
  localparam int MIN_W  = (WR_W < RD_W) ? WR_W : RD_W;
  localparam int MIN_SH = $clog2(MIN_W);
  localparam int IDX_W  = ADDR_W - MIN_SH;
  localparam int MEM_D  = 1 << IDX_W;
  localparam int WN     = WR_W / MIN_W;
  localparam int RN     = RD_W / MIN_W;

  logic [MIN_W-1:0] mem_q [MEM_D];
  logic [IDX_W-1:0] widx, ridx;
  logic [RD_W-1:0]  rdata_q;

  assign widx = IDX_W'(waddr_i >> MIN_SH);
  assign ridx = IDX_W'(raddr_i >> MIN_SH);

  always_ff @(posedge wclk_i) begin
    if (we_i) begin
      for (int k = 0; k < WN; k++) mem_q[widx + IDX_W'(k)] <= wdata_i[k*MIN_W +: MIN_W];
    end
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (re_i) begin
      for (int k = 0; k < RN; k++) rdata_q[k*MIN_W +: MIN_W] <= mem_q[ridx + IDX_W'(k)];
    end
  end

  assign rdata_o = rdata_q;

  AST_RDATA_HOLD: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o)); // R8
endmodule

// File: rtl/mwfifo.sv
`timescale 1ns/1ps
module mwfifo #(
  parameter int ADDR_W = 12,
  parameter int WR_W   = 8,
  parameter int RD_W   = 4
) (
  input  logic              wclk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WR_W-1:0]   wdata_i,
  input  logic              fstop_i,
  input  logic [ADDR_W-1:0] afull_thr_i,
  output logic              full_o,
  output logic              afull_o,
  input  logic              rclk_i,
  input  logic              rd_en_i,
  output logic [RD_W-1:0]   rdata_o,
  input  logic              estop_i,
  input  logic [ADDR_W-1:0] aempty_thr_i,
  output logic              empty_o,
  output logic              aempty_o
);
  localparam int WR_SH = $clog2(WR_W);
  localparam int RD_SH = $clog2(RD_W);
  localparam int WCW   = ADDR_W + 1 - WR_SH;
  localparam int RCW   = ADDR_W + 1 - RD_SH;

  logic [WCW-1:0]    wgray;
  logic [RCW-1:0]    rgray;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              w_acc, r_acc;

  mwfifo_ctrl #(.ADDR_W(ADDR_W), .OWN_SH(WR_SH), .PEER_SH(RD_SH), .IS_WR(1'b1)) u_wr (
    .clk_i      (wclk_i),
    .rst_ni     (rst_ni),
    .req_i      (wr_en_i),
    .stop_i     (fstop_i),
    .thr_i      (afull_thr_i),
    .peer_gray_i(rgray),
    .own_gray_o (wgray),
    .addr_o     (waddr),
    .acc_o      (w_acc),
    .bound_o    (full_o),
    .thresh_o   (afull_o)
  );

  mwfifo_ctrl #(.ADDR_W(ADDR_W), .OWN_SH(RD_SH), .PEER_SH(WR_SH), .IS_WR(1'b0)) u_rd (
    .clk_i      (rclk_i),
    .rst_ni     (rst_ni),
    .req_i      (rd_en_i),
    .stop_i     (estop_i),
    .thr_i      (aempty_thr_i),
    .peer_gray_i(wgray),
    .own_gray_o (rgray),
    .addr_o     (raddr),
    .acc_o      (r_acc),
    .bound_o    (empty_o),
    .thresh_o   (aempty_o)
  );

  mwfifo_mem #(.ADDR_W(ADDR_W), .WR_W(WR_W), .RD_W(RD_W)) u_mem (
    .wclk_i (wclk_i),
    .we_i   (w_acc),
    .waddr_i(waddr),
    .wdata_i(wdata_i),
    .rclk_i (rclk_i),
    .rst_ni (rst_ni),
    .re_i   (r_acc),
    .raddr_i(raddr),
    .rdata_o(rdata_o)
  );
endmodule

// File: tb/mwfifo_tb.sv
`timescale 1ns/1ps
module mwfifo_tb;
  logic        wclk = 0, rclk = 0, rst_ni = 0;
  logic        wr_en = 0, rd_en = 0, fstop = 1, estop = 1;
  logic [7:0]  wdata = 0;
  logic [11:0] afull_thr = 12'd40, aempty_thr = 12'd16;
  logic        full, afull, empty, aempty;
  logic [3:0]  rdata;
  int          total = 0, fails = 0;

  always #2 wclk = ~wclk;
  initial begin #1; forever #2 rclk = ~rclk; end

  mwfifo u_dut (
    .wclk_i(wclk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wdata_i(wdata), .fstop_i(fstop),
    .afull_thr_i(afull_thr), .full_o(full), .afull_o(afull),
    .rclk_i(rclk), .rd_en_i(rd_en), .rdata_o(rdata), .estop_i(estop),
    .aempty_thr_i(aempty_thr), .empty_o(empty), .aempty_o(aempty)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge wclk); wr_en = 1; wdata = d;
    @(negedge wclk); wr_en = 0;
  endtask

  task automatic rd(output logic [3:0] d);
    @(negedge rclk); rd_en = 1;
    @(negedge rclk); rd_en = 0; d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge wclk);
    repeat (4) @(negedge rclk);
  endtask

  function automatic logic [7:0] fpat(int i); return 8'(i * 37 + 11); endfunction
  function automatic logic [7:0] gpat(int i); return 8'(i * 11 + 200); endfunction

  task automatic t_reset();
    @(negedge rclk);
    check("R1 empty", int'(empty), 1);
    check("R1 full", int'(full), 0);
    check("R1 aempty", int'(aempty), 1);
    check("R1 afull", int'(afull), 0);
  endtask

  task automatic t_empty_delay();
    logic [3:0] d;
    wr(8'hA5);
    @(negedge rclk); check("R7 empty after 1st edge", int'(empty), 1);
    @(negedge rclk); check("R7 empty after 2nd edge", int'(empty), 0);
    check("R6 aempty at 8 bits", int'(aempty), 1);
    rd(d); check("R2 R8 low nibble", int'(d), 5);
    rd(d); check("R2 high nibble", int'(d), 'hA);
    settle(); check("R4 empty after drain", int'(empty), 1);
  endtask

  task automatic t_empty_block();
    logic [3:0] d;
    rd(d); check("R9 rdata held on blocked read", int'(d), 'hA);
    wr(8'h3C); settle();
    rd(d); check("R9 pointer not moved", int'(d), 'hC);
    rd(d); check("R9 second nibble", int'(d), 3);
  endtask

  task automatic t_thresholds();
    logic [3:0] d;
    int bad = 0;
    for (int i = 0; i < 4; i++) wr(8'(8'h10 + i));
    settle();
    check("R5 afull at 32 bits", int'(afull), 0);
    check("R6 aempty at 32 bits", int'(aempty), 0);
    wr(8'h14); settle();
    check("R5 afull at 40 bits", int'(afull), 1);
    rd(d); settle();
    check("R5 afull at 36 bits", int'(afull), 0);
    for (int i = 1; i < 5; i++) rd(d);
    settle(); check("R6 aempty at 20 bits", int'(aempty), 0);
    rd(d); settle(); check("R6 aempty at 16 bits", int'(aempty), 1);
    check("R2 nibble 6", int'(d), 1);
    for (int i = 6; i < 10; i++) begin
      rd(d);
      if (d != ((i % 2 == 0) ? 4'(i / 2) : 4'h1)) bad++;
    end
    check("R2 threshold drain mismatches", bad, 0);
  endtask

  task automatic t_full();
    logic [3:0] d;
    int bad = 0;
    for (int i = 0; i < 511; i++) wr(fpat(i));
    check("R3 full at 4088 bits", int'(full), 0);
    wr(fpat(511));
    check("R3 full at 4096 bits", int'(full), 1);
    wr(8'hFF);
    check("R10 full after blocked write", int'(full), 1);
    rd(d); check("R10 oldest word kept", int'(d), int'(fpat(0) & 8'h0F));
    settle(); check("R3 full with 4 bits free", int'(full), 1);
    rd(d); settle(); check("R3 full with 8 bits free", int'(full), 0);
    wr(8'h5A); check("R3 full again", int'(full), 1);
    settle();
    for (int i = 1; i < 512; i++) begin
      rd(d); if (d != fpat(i)[3:0]) bad++;
      rd(d); if (d != fpat(i)[7:4]) bad++;
    end
    rd(d); if (d != 4'hA) bad++;
    rd(d); if (d != 4'h5) bad++;
    check("R10 drain mismatches", bad, 0);
    settle(); check("R4 empty after full drain", int'(empty), 1);
  endtask

  task automatic t_wrap();
    logic [3:0] d;
    int bad = 0;
    fstop = 0; estop = 0;
    for (int i = 0; i < 512; i++) wr(gpat(i));
    wr(8'hE7);
    check("R11 full after overwrite", int'(full), 1);
    settle();
    rd(d); check("R11 overwritten low", int'(d), 7);
    rd(d); check("R11 overwritten high", int'(d), 'hE);
    for (int i = 1; i < 512; i++) begin
      rd(d); if (d != gpat(i)[3:0]) bad++;
      rd(d); if (d != gpat(i)[7:4]) bad++;
    end
    check("R11 wrap drain mismatches", bad, 0);
    rd(d); rd(d); settle();
    check("R4 empty at wrapped level 0", int'(empty), 1);
    rd(d); check("R11 re-read after empty", int'(d), int'(gpat(1) & 8'h0F));
  endtask

  initial begin
    repeat (3) @(negedge wclk);
    t_reset();
    rst_ni = 1;
    settle();
    t_reset();
    t_empty_delay();
    t_empty_block();
    t_thresholds();
    t_full();
    t_wrap();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #600000;
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule